// File: doc/BRIEF.md
# Interrupt Redirection Dispatch Engine

This block sits between a set of interrupt request lines and the processor-side interrupt controller. It records requests from its input pins in a pending register. Each pin's 64-bit redirection entry arrives on a wide parallel bus, and the block looks up the pin's settings there. It scans the pending pins that are not masked and sends one delivery message at a time over a valid/ready handshake. A message carries the destination, destination mode, delivery mode, vector, polarity and trigger mode, plus the number of the pin it came from.

Edge-triggered and level-triggered pins are handled differently.
- **Edge pins:** a delivery consumes the pending request.
- **Level pins:** a delivery raises a per-pin acknowledge-outstanding flag, and the pin is not sent again while that flag is set. An end-of-interrupt broadcast carrying a vector clears the flag on every entry whose vector matches. A level pin whose input is still asserted is then sent again.

Two further features:
- **External-interrupt delivery mode:** the block fetches the vector from a legacy controller through a request/acknowledge exchange before it offers the message.
- **Pin-0 remap:** an optional setting steers input 0 onto pin 2.

Top module: `irq_dispatch_engine`

## Requirements
- R1: Entry fields are decoded at fixed positions: destination bits 63:56, mask bit 16 (1 = masked), trigger bit 15 (0 edge, 1 level), polarity bit 13, destination mode bit 11, delivery mode bits 10:8, vector bits 7:0. A message copies these fields from the winning pin's entry.
- R2: On an edge pin, a rising input sets the pending bit only if the entry is unmasked at that moment. A rise while masked is dropped, and unmasking later produces no message.
- R3: On a level pin, the pending bit follows the input level. A level pin that is pending and unmasked, with its flag clear, is delivered.
- R4: Servicing an edge pin clears its pending bit, so each edge gives exactly one message. Servicing a level pin sets its acknowledge flag on `rack_flags`, and the pin is not delivered again while the flag is set.
- R5: An end-of-interrupt clears the flag on every entry whose vector equals `eoi_vector` and leaves the others set. A cleared level pin that is still asserted and unmasked is delivered again.
- R6: Delivery mode 7 (external interrupt) raises `leg_req` and holds back `msg_valid` until `leg_ack`. The message then carries `leg_vector` in place of the entry's vector.
- R7: When several pins are eligible, the lowest-numbered pin is sent first and the others follow one at a time.
- R8: While `msg_valid` is high and `msg_ready` is low, the message and its pin number stay unchanged.
- R9: With `remap_pin0` set, a request on input 0 is handled as pin 2 and pin 0 sees no request.
- R10: After reset no message is offered, `leg_req` is low and all acknowledge flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | Interrupt request inputs |
| remap_pin0 | input | 1 | Steer input 0 onto pin 2 |
| rte_flat | input | NUM_PINS*64 | Redirection entries; pin i occupies bits 64*i+63 : 64*i |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| leg_req | output | 1 | Vector request to the legacy controller |
| leg_ack | input | 1 | Legacy controller has returned a vector |
| leg_vector | input | 8 | Vector returned by the legacy controller |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_dest | output | 8 | Destination |
| msg_dest_mode | output | 1 | Destination mode |
| msg_deliv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector |
| msg_polarity | output | 1 | Polarity |
| msg_trigger | output | 1 | Trigger mode (1 = level) |
| msg_pin | output | $clog2(NUM_PINS) | Source pin of the message |
| rack_flags | output | NUM_PINS | Per-pin acknowledge-outstanding flags |

## Verification
The bench builds the block with its default parameters: 24 pins, with the remap taking input 0 onto pin 2. This lets directed tests reach the remap pair at the bottom of the pin range, two widely separated pins competing in the same cycle, and level and external-interrupt pins in the middle. Random rounds drive simultaneous edges on random subsets of the upper eleven pins, with random destinations, vectors and non-legacy delivery modes. They check ascending delivery order and field placement against entries built by the bench.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    localparam int RTE_W = 64;
    localparam int VEC_W = 8;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_PMI    = 3'd2,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_SIPI   = 3'd6,
        DM_EXTINT = 3'd7
    } deliv_mode_e;

    typedef struct packed {
        logic [7:0]       dest;
        logic             masked;
        logic             level;
        logic             polarity;
        logic             dest_logical;
        deliv_mode_e      mode;
        logic [VEC_W-1:0] vector;
    } rte_fields_t;

    typedef struct packed {
        logic [7:0]       dest;
        logic             dest_mode;
        deliv_mode_e      mode;
        logic [VEC_W-1:0] vector;
        logic             polarity;
        logic             level;
    } dispatch_msg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEGACY = 2'd1,
        ST_SEND   = 2'd2
    } disp_state_e;

    function automatic rte_fields_t decode_rte(input logic [RTE_W-1:0] e);
        rte_fields_t f;
        f.dest         = e[63:56];
        f.masked       = e[16];
        f.level        = e[15];
        f.polarity     = e[13];
        f.dest_logical = e[11];
        f.mode         = deliv_mode_e'(e[10:8]);
        f.vector       = e[7:0];
        return f;
    endfunction

endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture #(
    parameter int NUM_PINS = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] src,
    input  logic [NUM_PINS-1:0] mask_vec,
    input  logic [NUM_PINS-1:0] level_vec,
    input  logic [NUM_PINS-1:0] svc_clr,
    output logic [NUM_PINS-1:0] pending
);

    logic [NUM_PINS-1:0] src_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic rise;
        assign rise = src[i] & ~src_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                src_q[i]   <= 1'b0;
                pending[i] <= 1'b0;
            end else begin
                src_q[i] <= src[i];
                if (level_vec[i])
                    pending[i] <= src[i];
                else
                    pending[i] <= (pending[i] & ~svc_clr[i]) | (rise & ~mask_vec[i]);
            end
        end

        // R2: a rise on a masked edge pin leaves an idle pin idle
        a_r2_masked_edge_dropped: assert property (@(posedge clk) disable iff (rst)
            (!level_vec[i] && mask_vec[i] && rise && !pending[i]) |=> !pending[i]);
    end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int NUM_REQ = 24,
    localparam int IDX_W = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    always_comb begin
        grant = '0;
        idx   = '0;
        any   = |req;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end

    // R7: one grant at most, and only to a requester
    a_r7_grant_legal: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~req) == '0) && (any == (grant != '0)));

endmodule

// File: rtl/irq_dispatch_engine.sv
module irq_dispatch_engine
    import irq_dispatch_pkg::*;
#(
    parameter int NUM_PINS  = 24,
    parameter int REMAP_SRC = 0,
    parameter int REMAP_DST = 2,
    localparam int PIN_W = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_PINS-1:0]       irq_in,
    input  logic                      remap_pin0,
    input  logic [NUM_PINS*RTE_W-1:0] rte_flat,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vector,
    output logic                      leg_req,
    input  logic                      leg_ack,
    input  logic [VEC_W-1:0]          leg_vector,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [7:0]                msg_dest,
    output logic                      msg_dest_mode,
    output logic [2:0]                msg_deliv_mode,
    output logic [VEC_W-1:0]          msg_vector,
    output logic                      msg_polarity,
    output logic                      msg_trigger,
    output logic [PIN_W-1:0]          msg_pin,
    output logic [NUM_PINS-1:0]       rack_flags
);

    rte_fields_t         fields [NUM_PINS];
    logic [NUM_PINS-1:0] mask_vec, level_vec, src, pending;
    logic [NUM_PINS-1:0] eligible, grant, svc_clr, rack_set, eoi_clr, rack;
    logic [PIN_W-1:0]    pick_idx, pin_q;
    logic                any, take;
    rte_fields_t         sel;
    dispatch_msg_t       msg_q;
    disp_state_e         state;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_decode
        assign fields[i]    = decode_rte(rte_flat[i*RTE_W +: RTE_W]);
        assign mask_vec[i]  = fields[i].masked;
        assign level_vec[i] = fields[i].level;
        assign eoi_clr[i]   = eoi_valid && rack[i] && (fields[i].vector == eoi_vector);
        if (i == REMAP_DST) begin : g_dst
            assign src[i] = remap_pin0 ? irq_in[REMAP_SRC] : irq_in[i];
        end else if (i == REMAP_SRC) begin : g_src
            assign src[i] = remap_pin0 ? 1'b0 : irq_in[i];
        end else begin : g_plain
            assign src[i] = irq_in[i];
        end
    end

    irq_pin_capture #(.NUM_PINS(NUM_PINS)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .mask_vec (mask_vec),
        .level_vec(level_vec),
        .svc_clr  (svc_clr),
        .pending  (pending)
    );

    assign eligible = pending & ~mask_vec & ~(level_vec & rack);

    irq_lowest_pick #(.NUM_REQ(NUM_PINS)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .req  (eligible),
        .grant(grant),
        .idx  (pick_idx),
        .any  (any)
    );

    assign take     = (state == ST_IDLE) && any;
    assign sel      = fields[pick_idx];
    assign svc_clr  = take ? (grant & ~level_vec) : '0;
    assign rack_set = take ? (grant & level_vec) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            msg_q <= '0;
            pin_q <= '0;
            rack  <= '0;
        end else begin
            rack <= (rack & ~eoi_clr) | rack_set;
            case (state)
                ST_IDLE: begin
                    if (any) begin
                        msg_q.dest      <= sel.dest;
                        msg_q.dest_mode <= sel.dest_logical;
                        msg_q.mode      <= sel.mode;
                        msg_q.vector    <= sel.vector;
                        msg_q.polarity  <= sel.polarity;
                        msg_q.level     <= sel.level;
                        pin_q           <= pick_idx;
                        state           <= (sel.mode == DM_EXTINT) ? ST_LEGACY : ST_SEND;
                    end
                end
                ST_LEGACY: begin
                    if (leg_ack) begin
                        msg_q.vector <= leg_vector;
                        state        <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (msg_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign leg_req        = (state == ST_LEGACY);
    assign msg_valid      = (state == ST_SEND);
    assign msg_dest       = msg_q.dest;
    assign msg_dest_mode  = msg_q.dest_mode;
    assign msg_deliv_mode = msg_q.mode;
    assign msg_vector     = msg_q.vector;
    assign msg_polarity   = msg_q.polarity;
    assign msg_trigger    = msg_q.level;
    assign msg_pin        = pin_q;
    assign rack_flags     = rack;

    // R8: a stalled message holds still
    a_r8_msg_hold: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_q) && $stable(pin_q)));

    // R6: the returned legacy vector is what gets offered
    a_r6_legacy_vector: assert property (@(posedge clk) disable iff (rst)
        (leg_req && leg_ack) |=> (msg_valid && msg_vector == $past(leg_vector)));

    // R4: a flagged level pin is never picked
    a_r4_no_flagged_pick: assert property (@(posedge clk) disable iff (rst)
        take |-> !(level_vec[pick_idx] && rack[pick_idx]));

    // R4: at most one flag is raised per cycle
    a_r4_single_flag_rise: assert property (@(posedge clk) disable iff (rst)
        $countones(rack & ~$past(rack)) <= 1);

endmodule

// File: tb/irq_dispatch_engine_bench.sv
module irq_dispatch_engine_bench;

    localparam int NP = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0] irq_in = '0;
    logic remap_pin0 = 1'b0;
    logic [63:0] ent [NP];
    logic [NP*64-1:0] rte_flat;
    logic eoi_valid = 1'b0;
    logic [7:0] eoi_vector = '0;
    logic leg_req, leg_ack = 1'b0;
    logic [7:0] leg_vector = '0;
    logic msg_valid, msg_ready = 1'b1;
    logic [7:0] msg_dest, msg_vector;
    logic msg_dest_mode, msg_polarity, msg_trigger;
    logic [2:0] msg_deliv_mode;
    logic [4:0] msg_pin;
    logic [NP-1:0] rack_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    always_comb
        for (int i = 0; i < NP; i++) rte_flat[i*64 +: 64] = ent[i];

    irq_dispatch_engine u_irq_dispatch_engine (
        .clk(clk), .rst(rst), .irq_in(irq_in), .remap_pin0(remap_pin0),
        .rte_flat(rte_flat), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .leg_req(leg_req), .leg_ack(leg_ack), .leg_vector(leg_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
        .msg_dest_mode(msg_dest_mode), .msg_deliv_mode(msg_deliv_mode),
        .msg_vector(msg_vector), .msg_polarity(msg_polarity),
        .msg_trigger(msg_trigger), .msg_pin(msg_pin), .rack_flags(rack_flags)
    );

    function automatic logic [63:0] mk(logic [7:0] dest, bit mask, bit lvl, bit pol,
                                       bit dm, logic [2:0] mode, logic [7:0] vec);
        logic [63:0] e = '0;
        e[63:56] = dest; e[16] = mask; e[15] = lvl; e[13] = pol;
        e[11] = dm; e[10:8] = mode; e[7:0] = vec;
        return e;
    endfunction

    function automatic logic [26:0] exp_msg(logic [63:0] e, int pin, logic [7:0] v);
        return {e[63:56], e[11], e[10:8], v, e[13], e[15], 5'(pin)};
    endfunction

    function automatic logic [26:0] act_msg();
        return {msg_dest, msg_dest_mode, msg_deliv_mode, msg_vector,
                msg_polarity, msg_trigger, msg_pin};
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(logic [NP-1:0] pins);
        @(negedge clk); irq_in = irq_in | pins;
        @(negedge clk); irq_in = irq_in & ~pins;
    endtask

    task automatic eoi(logic [7:0] v);
        @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic wait_msg(int pin, logic [7:0] v, string req);
        int n = 0;
        @(negedge clk);
        while (!msg_valid && n < 60) begin @(negedge clk); n++; end
        check(msg_valid, req, 64'(msg_valid), 64'd1);
        check(act_msg() == exp_msg(ent[pin], pin, v), req,
              64'(act_msg()), 64'(exp_msg(ent[pin], pin, v)));
    endtask

    task automatic count_msgs(int cycles, output int cnt);
        cnt = 0;
        repeat (cycles) begin @(negedge clk); if (msg_valid) cnt++; end
    endtask

    initial begin
        #2ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [63:0] held;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NP; i++) ent[i] = mk(8'h00, 1, 0, 0, 0, 3'd0, 8'h00);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(!msg_valid && !leg_req && rack_flags == '0, "R10",
              {msg_valid, leg_req, 38'd0, rack_flags}, 64'd0);

        // R1: field placement from an unmasked edge pin
        ent[5] = mk(8'h3c, 0, 0, 1, 1, 3'd1, 8'h41);
        pulse(NP'(1) << 5);
        wait_msg(5, 8'h41, "R1");
        count_msgs(6, cnt);
        check(cnt == 0, "R4 one message per edge", 64'(cnt), 64'd0);

        // R2: masked edge dropped, stays dropped after unmask
        ent[6] = mk(8'h01, 1, 0, 0, 0, 3'd0, 8'h61);
        pulse(NP'(1) << 6);
        count_msgs(8, cnt);
        check(cnt == 0, "R2 masked", 64'(cnt), 64'd0);
        ent[6][16] = 1'b0;
        count_msgs(8, cnt);
        check(cnt == 0, "R2 unmask later", 64'(cnt), 64'd0);
        pulse(NP'(1) << 6);
        wait_msg(6, 8'h61, "R2 unmasked edge");

        // R3 R4 R5: level pin and end-of-interrupt
        ent[9] = mk(8'h07, 0, 1, 0, 0, 3'd0, 8'h52);
        @(negedge clk); irq_in[9] = 1'b1;
        wait_msg(9, 8'h52, "R3 level delivered");
        @(negedge clk);
        check(rack_flags[9], "R4 flag set", 64'(rack_flags), 64'(1 << 9));
        count_msgs(10, cnt);
        check(cnt == 0, "R4 no redelivery while flagged", 64'(cnt), 64'd0);
        eoi(8'h53);
        count_msgs(6, cnt);
        check(cnt == 0 && rack_flags[9], "R5 vector mismatch", 64'(rack_flags), 64'(1 << 9));
        eoi(8'h52);
        wait_msg(9, 8'h52, "R5 redelivered");
        irq_in[9] = 1'b0;
        repeat (3) @(negedge clk);
        eoi(8'h52);
        count_msgs(8, cnt);
        check(cnt == 0 && rack_flags == '0, "R3 level low after eoi",
              {cnt[31:0], rack_flags[23:0], 8'd0}, 64'd0);

        // R6: external-interrupt vector fetch
        ent[11] = mk(8'h02, 0, 0, 0, 0, 3'd7, 8'h10);
        pulse(NP'(1) << 11);
        cnt = 0;
        while (!leg_req && cnt < 20) begin @(negedge clk); cnt++; end
        check(leg_req, "R6 request raised", 64'(leg_req), 64'd1);
        count_msgs(4, cnt);
        check(cnt == 0 && leg_req, "R6 held until ack", 64'(cnt), 64'd0);
        leg_ack = 1'b1; leg_vector = 8'h77;
        @(negedge clk); leg_ack = 1'b0;
        check(msg_valid && act_msg() == exp_msg(ent[11], 11, 8'h77), "R6 legacy vector",
              64'(act_msg()), 64'(exp_msg(ent[11], 11, 8'h77)));

        // R7: lowest pin first
        ent[3]  = mk(8'h33, 0, 0, 0, 0, 3'd4, 8'h83);
        ent[12] = mk(8'hc0, 0, 0, 1, 0, 3'd0, 8'h8c);
        pulse((NP'(1) << 3) | (NP'(1) << 12));
        wait_msg(3, 8'h83, "R7 first");
        wait_msg(12, 8'h8c, "R7 second");

        // R9: remap input 0 to pin 2
        ent[0] = mk(8'h10, 0, 0, 0, 0, 3'd0, 8'h20);
        ent[2] = mk(8'h12, 0, 0, 0, 0, 3'd0, 8'h22);
        @(negedge clk); remap_pin0 = 1'b1;
        pulse(NP'(1));
        wait_msg(2, 8'h22, "R9 remapped");
        count_msgs(6, cnt);
        check(cnt == 0, "R9 pin 0 idle", 64'(cnt), 64'd0);
        @(negedge clk); remap_pin0 = 1'b0;

        // R8: stall holds message
        ent[4] = mk(8'h44, 0, 0, 0, 1, 3'd5, 8'h94);
        @(negedge clk); msg_ready = 1'b0;
        pulse(NP'(1) << 4);
        cnt = 0;
        while (!msg_valid && cnt < 20) begin @(negedge clk); cnt++; end
        held = 64'(act_msg());
        repeat (5) @(negedge clk);
        check(msg_valid && 64'(act_msg()) == held, "R8 hold", 64'(act_msg()), held);
        msg_ready = 1'b1;
        check(held == 64'(exp_msg(ent[4], 4, 8'h94)), "R8 content", held,
              64'(exp_msg(ent[4], 4, 8'h94)));
        @(negedge clk);

        // R7 R1: random rounds on pins 13..23
        for (int r = 0; r < 20; r++) begin
            logic [NP-1:0] sel;
            sel = '0;
            while (sel == '0) sel = NP'($urandom_range(0, 2047)) << 13;
            for (int p = 13; p < NP; p++) begin
                logic [2:0] m;
                m = 3'($urandom_range(0, 5));
                if (m == 3'd3) m = 3'd0;
                if (m == 3'd7) m = 3'd6;
                ent[p] = mk(8'($urandom), 0, 0, 1'($urandom), 1'($urandom), m, 8'($urandom));
            end
            pulse(sel);
            for (int p = 13; p < NP; p++)
                if (sel[p]) wait_msg(p, ent[p][7:0], "R7 random order");
            count_msgs(3, cnt);
            check(cnt == 0, "R7 random no extra", 64'(cnt), 64'd0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule